// File: doc/BRIEF.md
# Uncached Load/Store Data Aligner

This block is the data-path stage for memory operations that bypass the cache. One operation at a time is accepted on a valid/ready input stream. Each operation carries a 4-bit type code, a byte address and one register operand. For loads the operand is the old value of the destination register. For stores it is the source value.

The block decodes the operation and checks its alignment. It then issues one aligned word access on a simple request/response memory port. For a load, the block shapes the returned word into the value written back to the register. It can extract a byte or halfword, apply sign or zero extension, or merge a partial word into the old register contents. For a store, the block positions the data and byte enables on the aligned word.

Three further cases are handled. A word load at an address whose low two bits are `01` is an atomic test-and-set. A bus error suppresses the writeback. When the configured uncached latency is above one cycle, the writeback result is held back by that many cycles. The outcome leaves on a valid/ready result stream.

Back-pressure rules are as follows:
- `in_ready` is high only while no operation is in flight.
- `mem_req_*` holds its payload while `mem_req_valid` is high and `mem_req_ready` is low.
- `res_*` holds its payload while `res_valid` is high and `res_ready` is low.
- The memory response has no ready signal: the block always takes it while waiting.

Top module: `ualign_top`

## Requirements
- R1: After reset, `in_ready` is 1, and `res_valid` and `mem_req_valid` are 0.
- R2: Loads select data from the returned word in little-endian order. Byte lane = addr[1:0] and halfword lane = addr[1]. Code 0 is zero-extended byte, 4 is sign-extended byte, 1 is zero-extended halfword, 5 is sign-extended halfword, and 6 at addr[1:0]=00 is a full word.
- R3: Load-left (code 2) with s = 8*addr[1:0] returns the old register bits below bit s, with the memory word shifted left by s above them.
- R4: Load-right (code 3) with t = 8*(3-addr[1:0]) and m = 0xFFFFFF00 << (24-t) returns old AND m, OR'd with (memory word >> t) AND NOT m.
- R5: Every memory request uses the word address: the operation address with its two low bits cleared.
- R6: A fault is raised by halfword codes 1, 5 and 9 when addr[0]=1. It is raised by code 6 when addr[1:0] is 10 or 11, and by code 10 when addr[1:0]≠0. Codes 11 and 12 (store-left/right) and the undefined codes 7, 13, 14 and 15 always fault. A faulting operation issues no memory request and returns `res_fault`=1 and `res_wb_en`=0. Byte and partial codes 0, 2, 3, 4 and 8 never fault.
- R7: Stores with code 8 (byte), 9 (halfword) and 10 (word) write the low byte, halfword or word of the operand into its lane of the aligned word. Only that lane's byte enables are set, and `res_wb_en`=0.
- R8: Code 6 at addr[1:0]=01 reads the aligned word. If bit 0 is set, the result is 0 and nothing is written. Otherwise the word is written to 1 with all enables set and the result is 1.
- R9: A response with `mem_rsp_err`=1 ends the operation with `res_err`=1 and `res_wb_en`=0, and a store with an error writes nothing.
- R10: A writeback result becomes visible UC_LAT-1 clocks after the edge that takes the final memory response, or right after that edge when UC_LAT ≤ 1.
- R11: Request and result payloads stay stable while stalled, and a result is presented exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation accepted when high with in_valid |
| in_op | input | 4 | Operation type code |
| in_addr | input | AW | Byte address |
| in_reg | input | 32 | Old destination value (load) or source value (store) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | AW | Word-aligned address |
| mem_req_wdata | output | 32 | Write data placed in lanes |
| mem_req_be | output | 4 | Byte enables of the write |
| mem_rsp_valid | input | 1 | Memory response present |
| mem_rsp_rdata | input | 32 | Word read |
| mem_rsp_err | input | 1 | Bus error on this response |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result consumed |
| res_wb_en | output | 1 | Register is to be written |
| res_data | output | 32 | Register write value |
| res_fault | output | 1 | Misalignment or unsupported-type fault |
| res_err | output | 1 | Bus error reported |

## Verification
Byte and halfword loads are run over every lane against a word holding bytes with the top bit both set and clear. This separates lane selection from extension and signed from unsigned handling. The partial loads use an old register value and a memory word with distinct bytes at all four offsets, so any off-by-one byte in a shift or mask shows up in the merged result.

Stores are checked through the memory contents they leave behind. Test-and-set is run on a word with bit 0 clear and then again on the same word, to see both outcomes. Faulting codes, injected bus errors and a stalled result port show that nothing reaches memory or the register when it must not, and that payloads hold while stalled.

// File: rtl/ualign_pkg.sv
package ualign_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned BE_W   = WORD_W / 8;

  typedef enum logic [3:0] {
    OP_LBU = 4'd0,
    OP_LHU = 4'd1,
    OP_LWL = 4'd2,
    OP_LWR = 4'd3,
    OP_LB  = 4'd4,
    OP_LH  = 4'd5,
    OP_LW  = 4'd6,
    OP_SB  = 4'd8,
    OP_SH  = 4'd9,
    OP_SW  = 4'd10,
    OP_SWL = 4'd11,
    OP_SWR = 4'd12
  } ua_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_RSP,
    ST_TAS_REQ,
    ST_TAS_RSP,
    ST_WAIT,
    ST_RES
  } ua_state_e;

  typedef struct packed {
    logic              wb;
    logic              fault;
    logic              err;
    logic [WORD_W-1:0] data;
  } ua_res_t;

endpackage

// File: rtl/ualign_decode.sv
module ualign_decode
  import ualign_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic [3:0]        op,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] src,
  output logic              fault,
  output logic              is_store,
  output logic              is_tas,
  output logic [AW-1:0]     word_addr,
  output logic [WORD_W-1:0] st_data,
  output logic [BE_W-1:0]   st_be
);

  logic [1:0] lane;
  assign lane      = addr[1:0];
  assign word_addr = {addr[AW-1:2], 2'b00};

  always_comb begin
    fault    = 1'b0;
    is_store = 1'b0;
    is_tas   = 1'b0;
    st_data  = '0;
    st_be    = '0;
    case (op)
      OP_LBU, OP_LB, OP_LWL, OP_LWR: fault = 1'b0;
      OP_LHU, OP_LH:                 fault = lane[0];
      OP_LW: begin
        // lane 01 is the test-and-set form; lanes 10/11 are misaligned
        fault  = lane[1];
        is_tas = (lane == 2'b01);
      end
      OP_SB: begin
        is_store = 1'b1;
        st_data  = {{(WORD_W-8){1'b0}}, src[7:0]} << {lane, 3'b000};
        st_be    = BE_W'(1) << lane;
      end
      OP_SH: begin
        is_store = 1'b1;
        fault    = lane[0];
        st_data  = {{(WORD_W-16){1'b0}}, src[15:0]} << {lane[1], 4'b0000};
        st_be    = BE_W'(3) << {lane[1], 1'b0};
      end
      OP_SW: begin
        is_store = 1'b1;
        fault    = |lane;
        st_data  = src;
        st_be    = '1;
      end
      OP_SWL, OP_SWR: fault = 1'b1;
      default:        fault = 1'b1;
    endcase
  end

endmodule

// File: rtl/ualign_merge.sv
module ualign_merge
  import ualign_pkg::*;
(
  input  logic [3:0]        op,
  input  logic [1:0]        lane,
  input  logic [WORD_W-1:0] rdata,
  input  logic [WORD_W-1:0] old,
  output logic [WORD_W-1:0] result
);

  logic [4:0]        up_sh;
  logic [4:0]        dn_sh;
  logic [7:0]        sel_b;
  logic [15:0]       sel_h;
  logic [WORD_W-1:0] keep_lo;
  logic [WORD_W-1:0] keep_hi;

  assign up_sh   = {lane, 3'b000};
  assign dn_sh   = {~lane, 3'b000};
  assign sel_b   = 8'(rdata >> up_sh);
  assign sel_h   = lane[1] ? rdata[31:16] : rdata[15:0];
  assign keep_lo = ~({WORD_W{1'b1}} << up_sh);
  // 0xFFFFFF00 << (24 - dn_sh) equals 0xFFFFFF00 << up_sh
  assign keep_hi = 32'hFFFF_FF00 << up_sh;

  always_comb begin
    case (op)
      OP_LBU:  result = {{(WORD_W-8){1'b0}}, sel_b};
      OP_LB:   result = {{(WORD_W-8){sel_b[7]}}, sel_b};
      OP_LHU:  result = {{(WORD_W-16){1'b0}}, sel_h};
      OP_LH:   result = {{(WORD_W-16){sel_h[15]}}, sel_h};
      OP_LWL:  result = (old & keep_lo) | (rdata << up_sh);
      OP_LWR:  result = (old & keep_hi) | ((rdata >> dn_sh) & ~keep_hi);
      OP_LW:   result = rdata;
      default: result = '0;
    endcase
  end

endmodule

// File: rtl/ualign_lat_timer.sv
module ualign_lat_timer #(
  parameter int unsigned UC_LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);

  generate
    if (UC_LAT > 1) begin : g_cnt
      localparam int unsigned      CW   = $clog2(UC_LAT + 1);
      localparam logic [CW-1:0]    LOAD = CW'(UC_LAT - 2);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= LOAD;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
      end

      assign expired = (cnt == '0);

      p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LOAD);
      p_cnt_falls_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
    end else begin : g_none
      assign expired = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/ualign_top.sv
module ualign_top
  import ualign_pkg::*;
#(
  parameter int unsigned AW     = 16,
  parameter int unsigned UC_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_op,
  input  logic [AW-1:0]     in_addr,
  input  logic [WORD_W-1:0] in_reg,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [AW-1:0]     mem_req_addr,
  output logic [WORD_W-1:0] mem_req_wdata,
  output logic [BE_W-1:0]   mem_req_be,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_rdata,
  input  logic              mem_rsp_err,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_wb_en,
  output logic [WORD_W-1:0] res_data,
  output logic              res_fault,
  output logic              res_err
);

  localparam ua_state_e AFTER_LD = (UC_LAT > 1) ? ST_WAIT : ST_RES;

  ua_state_e         st;
  logic [3:0]        op_q;
  logic [1:0]        lane_q;
  logic [WORD_W-1:0] reg_q;
  logic              store_q;
  logic              tas_q;
  logic [AW-1:0]     waddr_q;
  logic [WORD_W-1:0] sdata_q;
  logic [BE_W-1:0]   sbe_q;
  ua_res_t           res_q;

  logic              dec_fault;
  logic              dec_store;
  logic              dec_tas;
  logic [AW-1:0]     dec_waddr;
  logic [WORD_W-1:0] dec_sdata;
  logic [BE_W-1:0]   dec_sbe;
  logic [WORD_W-1:0] merged;
  logic              ld_done;
  logic              lat_expired;

  ualign_decode #(.AW(AW)) u_decode (
    .op        (in_op),
    .addr      (in_addr),
    .src       (in_reg),
    .fault     (dec_fault),
    .is_store  (dec_store),
    .is_tas    (dec_tas),
    .word_addr (dec_waddr),
    .st_data   (dec_sdata),
    .st_be     (dec_sbe)
  );

  ualign_merge u_merge (
    .op     (op_q),
    .lane   (lane_q),
    .rdata  (mem_rsp_rdata),
    .old    (reg_q),
    .result (merged)
  );

  // A load finishes with a writeback: plain load, TAS that found bit 0 set,
  // or the closing write of a TAS.
  assign ld_done =
      (st == ST_RSP && mem_rsp_valid && !mem_rsp_err && !store_q &&
       !(tas_q && !mem_rsp_rdata[0])) ||
      (st == ST_TAS_RSP && mem_rsp_valid && !mem_rsp_err);

  ualign_lat_timer #(.UC_LAT(UC_LAT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (ld_done),
    .expired (lat_expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      op_q    <= '0;
      lane_q  <= '0;
      reg_q   <= '0;
      store_q <= 1'b0;
      tas_q   <= 1'b0;
      waddr_q <= '0;
      sdata_q <= '0;
      sbe_q   <= '0;
      res_q   <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (in_valid) begin
            op_q    <= in_op;
            lane_q  <= in_addr[1:0];
            reg_q   <= in_reg;
            store_q <= dec_store;
            tas_q   <= dec_tas;
            waddr_q <= dec_waddr;
            sdata_q <= dec_sdata;
            sbe_q   <= dec_sbe;
            res_q   <= '0;
            if (dec_fault) begin
              res_q.fault <= 1'b1;
              st          <= ST_RES;
            end else begin
              st <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (mem_req_ready) st <= ST_RSP;
        end
        ST_RSP: begin
          if (mem_rsp_valid) begin
            if (mem_rsp_err) begin
              res_q.err <= 1'b1;
              st        <= ST_RES;
            end else if (store_q) begin
              st <= ST_RES;
            end else if (tas_q) begin
              if (mem_rsp_rdata[0]) begin
                res_q.data <= '0;
                res_q.wb   <= 1'b1;
                st         <= AFTER_LD;
              end else begin
                res_q.data <= WORD_W'(1);
                st         <= ST_TAS_REQ;
              end
            end else begin
              res_q.data <= merged;
              res_q.wb   <= 1'b1;
              st         <= AFTER_LD;
            end
          end
        end
        ST_TAS_REQ: begin
          if (mem_req_ready) st <= ST_TAS_RSP;
        end
        ST_TAS_RSP: begin
          if (mem_rsp_valid) begin
            if (mem_rsp_err) begin
              res_q.err <= 1'b1;
              st        <= ST_RES;
            end else begin
              res_q.wb <= 1'b1;
              st       <= AFTER_LD;
            end
          end
        end
        ST_WAIT: begin
          if (lat_expired) st <= ST_RES;
        end
        ST_RES: begin
          if (res_ready) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign in_ready      = (st == ST_IDLE);
  assign mem_req_valid = (st == ST_REQ) || (st == ST_TAS_REQ);
  assign mem_req_we    = (st == ST_TAS_REQ) || store_q;
  assign mem_req_addr  = waddr_q;
  assign mem_req_wdata = (st == ST_TAS_REQ) ? WORD_W'(1) : sdata_q;
  assign mem_req_be    = (st == ST_TAS_REQ) ? '1 : (store_q ? sbe_q : '0);
  assign res_valid     = (st == ST_RES);
  assign res_wb_en     = res_q.wb;
  assign res_data      = res_q.data;
  assign res_fault     = res_q.fault;
  assign res_err       = res_q.err;

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wdata) &&
       $stable(mem_req_be) && $stable(mem_req_we)));

  p_res_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=>
      (res_valid && $stable(res_data) && $stable(res_wb_en) &&
       $stable(res_fault) && $stable(res_err)));

  p_res_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> !res_valid);

  p_fault_nowb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault) |-> (!res_wb_en && !res_err));

  p_fault_noreq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && dec_fault) |=> !mem_req_valid);

  p_err_nowb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_err) |-> !res_wb_en);

  p_store_nowb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && store_q) |-> !res_wb_en);

  p_word_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

endmodule

// File: tb/ualign_top_bench.sv
module ualign_top_bench;

  localparam int LAT = 3;
  localparam int AW  = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [3:0]    in_op = '0;
  logic [AW-1:0] in_addr = '0;
  logic [31:0]   in_reg = '0;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b0;
  logic          mem_req_we;
  logic [AW-1:0] mem_req_addr;
  logic [31:0]   mem_req_wdata;
  logic [3:0]    mem_req_be;
  logic          mem_rsp_valid = 1'b0;
  logic [31:0]   mem_rsp_rdata = '0;
  logic          mem_rsp_err = 1'b0;
  logic          res_valid;
  logic          res_ready = 1'b1;
  logic          res_wb_en;
  logic [31:0]   res_data;
  logic          res_fault;
  logic          res_err;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  int rsp_cyc = 0;
  int req_cnt = 0;
  logic [AW-1:0] last_req_addr = '0;
  logic [31:0] mem [16];
  bit inj_err = 1'b0;
  bit pend = 1'b0;
  bit pend_err = 1'b0;
  logic [31:0] pend_data = '0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ualign_top #(.AW(AW), .UC_LAT(LAT)) u_ualign_top (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_addr(in_addr), .in_reg(in_reg),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_req_be(mem_req_be),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .mem_rsp_err(mem_rsp_err),
    .res_valid(res_valid), .res_ready(res_ready), .res_wb_en(res_wb_en),
    .res_data(res_data), .res_fault(res_fault), .res_err(res_err)
  );

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (mem_rsp_valid) rsp_cyc = cyc;
  end

  // memory model: answers one cycle after each accepted request
  always @(negedge clk) begin
    mem_rsp_valid = pend;
    mem_rsp_rdata = pend_data;
    mem_rsp_err   = pend_err;
    pend = 1'b0;
    mem_req_ready = ((cyc % 3) != 1);
    if (mem_req_valid && mem_req_ready) begin
      int idx;
      idx = int'(mem_req_addr[5:2]);
      req_cnt = req_cnt + 1;
      last_req_addr = mem_req_addr;
      pend = 1'b1;
      pend_err = inj_err;
      pend_data = mem[idx];
      if (mem_req_we && !inj_err) begin
        for (int b = 0; b < 4; b++)
          if (mem_req_be[b]) mem[idx][8*b +: 8] = mem_req_wdata[8*b +: 8];
      end
    end
  end

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic model(input logic [3:0] op, input logic [15:0] addr,
                       input logic [31:0] rv, input logic [31:0] pre, input bit inj,
                       output bit f, output bit wb, output logic [31:0] d,
                       output bit er, output logic [31:0] nm, output int nreq);
    int ln;
    bit st;
    logic [7:0] by;
    logic [15:0] hw;
    ln = int'(addr[1:0]);
    st = (op == 4'd8 || op == 4'd9 || op == 4'd10);
    case (op)
      4'd0, 4'd2, 4'd3, 4'd4, 4'd8: f = 1'b0;
      4'd1, 4'd5, 4'd9:             f = (ln % 2) == 1;
      4'd6:                         f = (ln >= 2);
      4'd10:                        f = (ln != 0);
      default:                      f = 1'b1;
    endcase
    by = pre[8*ln +: 8];
    hw = (ln >= 2) ? pre[31:16] : pre[15:0];
    d = '0;
    case (op)
      4'd0: d = 32'(by);
      4'd4: d = 32'($signed(by));
      4'd1: d = 32'(hw);
      4'd5: d = 32'($signed(hw));
      4'd2: for (int k = 0; k < 4; k++)
              d[8*k +: 8] = (k < ln) ? rv[8*k +: 8] : pre[8*(k-ln) +: 8];
      4'd3: for (int k = 0; k < 4; k++)
              d[8*k +: 8] = (k <= ln) ? pre[8*(k+3-ln) +: 8] : rv[8*k +: 8];
      4'd6: d = (ln == 1) ? (pre[0] ? 32'd0 : 32'd1) : pre;
      default: d = '0;
    endcase
    nm = pre;
    nreq = f ? 0 : 1;
    if (!f && !inj) begin
      if (op == 4'd8) nm[8*ln +: 8] = rv[7:0];
      if (op == 4'd9) nm[8*(ln/2)*2 +: 16] = rv[15:0];
      if (op == 4'd10) nm = rv;
      if (op == 4'd6 && ln == 1 && !pre[0]) begin
        nm = 32'd1;
        nreq = 2;
      end
    end
    wb = !f && !inj && !st;
    er = !f && inj;
  endtask

  task automatic run_op(input logic [3:0] op, input logic [15:0] addr,
                        input logic [31:0] rv, input bit inj, input bit hold,
                        input string rq);
    int idx, base, wd, dl;
    logic [31:0] pre, e_d, e_m, snap;
    bit e_f, e_wb, e_er;
    int e_n;
    idx = int'(addr[5:2]);
    pre = mem[idx];
    model(op, addr, rv, pre, inj, e_f, e_wb, e_d, e_er, e_m, e_n);
    inj_err = inj;
    base = req_cnt;
    in_valid = 1'b1; in_op = op; in_addr = addr; in_reg = rv;
    check(in_ready == 1'b1, "R11", "in_ready when idle", 32'(in_ready), 32'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    wd = 0;
    while (!res_valid && wd < 200) begin
      @(negedge clk);
      wd++;
    end
    check(res_valid == 1'b1, rq, "result arrives", 32'(res_valid), 32'd1);
    if (e_wb) begin
      dl = cyc - rsp_cyc;
      check(dl == ((LAT > 1) ? LAT - 1 : 0), "R10", "writeback delay",
            32'(dl), 32'((LAT > 1) ? LAT - 1 : 0));
    end
    snap = res_data;
    if (hold) begin
      res_ready = 1'b0;
      for (int h = 0; h < 2; h++) begin
        @(negedge clk);
        check(res_valid && res_data == snap, "R11", "held result stable",
              res_data, snap);
      end
      res_ready = 1'b1;
    end
    check(res_fault == e_f, rq, "fault", 32'(res_fault), 32'(e_f));
    check(res_wb_en == e_wb, rq, "wb_en", 32'(res_wb_en), 32'(e_wb));
    check(res_err == e_er, rq, "err", 32'(res_err), 32'(e_er));
    if (e_wb) check(res_data == e_d, rq, "data", res_data, e_d);
    @(posedge clk);
    @(negedge clk);
    check(!res_valid, "R11", "result presented once", 32'(res_valid), 32'd0);
    check(mem[idx] == e_m, rq, "memory word", mem[idx], e_m);
    check(req_cnt - base == e_n, rq, "request count", 32'(req_cnt - base), 32'(e_n));
    if (e_n > 0)
      check(last_req_addr == {addr[15:2], 2'b00}, "R5", "aligned request address",
            32'(last_req_addr), 32'({addr[15:2], 2'b00}));
    inj_err = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h1000_0000 + 32'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(in_ready == 1'b1, "R1", "in_ready after reset", 32'(in_ready), 32'd1);
    check(res_valid == 1'b0, "R1", "res_valid after reset", 32'(res_valid), 32'd0);
    check(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset",
          32'(mem_req_valid), 32'd0);

    // R2 byte and halfword loads, all lanes
    mem[1] = 32'h80F1_7F02;
    for (int a = 4; a < 8; a++) run_op(4'd0, 16'(a), 32'hDEAD_BEEF, 0, 0, "R2");
    for (int a = 4; a < 8; a++) run_op(4'd4, 16'(a), 32'hDEAD_BEEF, 0, 0, "R2");
    run_op(4'd1, 16'd4, 32'h0, 0, 0, "R2");
    run_op(4'd1, 16'd6, 32'h0, 0, 1, "R2");
    run_op(4'd5, 16'd4, 32'h0, 0, 0, "R2");
    run_op(4'd5, 16'd6, 32'h0, 0, 0, "R2");
    mem[2] = 32'hCAFE_F00D;
    run_op(4'd6, 16'd8, 32'h0, 0, 0, "R2");

    // R3 / R4 partial merges
    mem[3] = 32'hA1B2_C3D4;
    for (int a = 12; a < 16; a++) run_op(4'd2, 16'(a), 32'h1122_3344, 0, 0, "R3");
    for (int a = 12; a < 16; a++) run_op(4'd3, 16'(a), 32'h1122_3344, 0, 0, "R4");

    // R6 faults
    run_op(4'd5, 16'd5, 32'h0, 0, 0, "R6");
    run_op(4'd1, 16'd7, 32'h0, 0, 0, "R6");
    run_op(4'd6, 16'd10, 32'h0, 0, 0, "R6");
    run_op(4'd6, 16'd11, 32'h0, 0, 1, "R6");
    run_op(4'd9, 16'd21, 32'h5555, 0, 0, "R6");
    run_op(4'd10, 16'd26, 32'h5555, 0, 0, "R6");
    run_op(4'd11, 16'd24, 32'h5555, 0, 0, "R6");
    run_op(4'd12, 16'd24, 32'h5555, 0, 0, "R6");
    run_op(4'd7, 16'd24, 32'h5555, 0, 0, "R6");
    run_op(4'd13, 16'd24, 32'h5555, 0, 0, "R6");
    run_op(4'd15, 16'd24, 32'h5555, 0, 0, "R6");

    // R7 stores
    mem[4] = 32'h0;
    for (int a = 16; a < 20; a++) run_op(4'd8, 16'(a), 32'hFFFF_FF00 + 32'(a), 0, 0, "R7");
    mem[5] = 32'h0;
    run_op(4'd9, 16'd20, 32'hAAAA_1234, 0, 0, "R7");
    run_op(4'd9, 16'd22, 32'hBBBB_5678, 0, 1, "R7");
    run_op(4'd10, 16'd24, 32'h0BAD_CAFE, 0, 0, "R7");

    // R8 test-and-set: clear then already set
    mem[7] = 32'h0000_0010;
    run_op(4'd6, 16'd29, 32'h7777_7777, 0, 0, "R8");
    run_op(4'd6, 16'd29, 32'h7777_7777, 0, 1, "R8");

    // R9 bus errors
    mem[8] = 32'h1234_5678;
    run_op(4'd6, 16'd32, 32'h0, 1, 0, "R9");
    mem[9] = 32'h2222_2222;
    run_op(4'd10, 16'd36, 32'h9999_9999, 1, 0, "R9");
    mem[10] = 32'h0;
    run_op(4'd6, 16'd41, 32'h0, 1, 1, "R9");
    run_op(4'd2, 16'd33, 32'h4444_4444, 1, 0, "R9");

    // recovery after error
    run_op(4'd3, 16'd34, 32'h4444_4444, 0, 0, "R4");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule